// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Ready and Empty Flags

This block is the send half of an asynchronous serial port. A processor-style write port loads bytes into a one-entry holding register. Whenever the shift stage is free, the held byte moves into it and goes out on the line. Each frame is one start bit, the data bits least significant first, and one stop bit. A baud tick input sets the bit rate: every bit lasts a fixed number of ticks. Software can then queue the next byte while the current one is still being shifted.

Two status flags report progress. The ready flag rises when a byte moves from the holding register into the shift stage, which means the holding register can accept another byte. A write clears it. The empty flag shows that neither stage holds data. A level interrupt follows the ready flag through an enable bit. The flags keep working with the interrupt masked, so software can poll them. A transmitter enable and a software reset each flush both stages and drop any pending request.

The shift stage is a four-state machine. IDLE goes to START on a handoff. START goes to DATA when the start bit's last tick arrives. DATA goes to STOP after the last data bit's final tick. STOP goes to IDLE after the stop bit's final tick. Any state goes to IDLE when the transmitter is inactive.

Top module: `uart_tx_dbuf`

## Requirements
- R1: The line idles at 1. A frame sends a 0 start bit, then the data byte with bit 0 first, then a 1 stop bit.
- R2: Every start, data and stop bit is held for exactly TICKS_PER_BIT asserted baud_tick cycles.
- R3: An accepted write clears ready_flag on the next clock. ready_flag rises on the clock edge where the held byte moves into the shift stage.
- R4: A handoff happens on the first clock on which the holding register is full and the shift stage is in IDLE. That is the clock after a write to an idle transmitter, or the clock after the stop bit ends. The start bit begins on the same edge as the handoff.
- R5: empty_flag is 1 exactly when the transmitter is active, the holding register is empty and the shift stage is in IDLE.
- R6: tx_irq is ready_flag gated by irq_enable. Clearing irq_enable only masks the request. Setting it again while ready_flag is 1 brings tx_irq back.
- R7: ready_flag and empty_flag behave the same whether irq_enable is 0 or 1.
- R8: While tx_enable is 0 or sw_reset is 1, both stages are flushed, ready_flag is 0, txd is 1, and writes are ignored. No request returns until a new byte is written and handed off.
- R9: A write while the holding register is full replaces the held byte. Only the last byte written is sent.
- R10: After a hardware reset, txd is 1, ready_flag is 0 and tx_irq is 0. empty_flag is 1 if the transmitter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| tx_enable | input | 1 | Transmitter enable (0 flushes) |
| sw_reset | input | 1 | Software reset (1 flushes) |
| irq_enable | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | Sub-bit rate tick |
| txd | output | 1 | Serial output line |
| ready_flag | output | 1 | Holding register can take a byte |
| empty_flag | output | 1 | Both stages empty |
| tx_irq | output | 1 | Level transmit interrupt |

## Verification
The bench builds the block with DATA_W at 8 and TICKS_PER_BIT at 4, and pulses baud_tick on every third clock. A full frame therefore takes 120 clocks. This short frame lets one run cover several back-to-back frames, a rewrite of the held byte mid-frame, masking and unmasking of the interrupt, and flushes by disable and by software reset, each at different points in a frame. A ready interval that is not a multiple of three keeps tick phases varying against the bit boundaries.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              ready
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full  <= 1'b0;
            data  <= '0;
            ready <= 1'b0;
        end else if (!active) begin
            full  <= 1'b0;
            ready <= 1'b0;
        end else begin
            if (load) begin
                full  <= 1'b0;
                ready <= 1'b1;
            end
            // a write in the same cycle wins over the handoff
            if (wr_en) begin
                full  <= 1'b1;
                data  <= wr_data;
                ready <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              idle
);
    localparam int TCW = $clog2(TICKS_PER_BIT);
    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [TCW-1:0] TICK_LAST = TCW'(TICKS_PER_BIT - 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [TCW-1:0]    tick_q;
    logic [BCW-1:0]    bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              bit_end;

    assign bit_end = baud_tick && (tick_q == TICK_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (load) state_d = S_START;
            S_START: if (bit_end) state_d = S_DATA;
            S_DATA:  if (bit_end && bit_q == BIT_LAST) state_d = S_STOP;
            S_STOP:  if (bit_end) state_d = S_IDLE;
        endcase
        if (!active) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
        end else if (!active || load) begin
            tick_q <= '0;
            bit_q  <= '0;
            sh_q   <= load_data;
        end else if (state_q != S_IDLE && baud_tick) begin
            tick_q <= bit_end ? '0 : tick_q + 1'b1;
            if (bit_end && state_q == S_DATA) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  txd = 1'b1;
            S_START: txd = 1'b0;
            S_DATA:  txd = sh_q[0];
            S_STOP:  txd = 1'b1;
        endcase
    end

    assign idle = (state_q == S_IDLE);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              sw_reset,
    input  logic              irq_enable,
    input  logic              baud_tick,
    output logic              txd,
    output logic              ready_flag,
    output logic              empty_flag,
    output logic              tx_irq
);
    logic              active;
    logic              hb_full;
    logic [DATA_W-1:0] hb_data;
    logic              sh_idle;
    logic              handoff;

    assign active  = tx_enable && !sw_reset;
    assign handoff = active && hb_full && sh_idle;

    uart_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load    (handoff),
        .full    (hb_full),
        .data    (hb_data),
        .ready   (ready_flag)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .baud_tick (baud_tick),
        .load      (handoff),
        .load_data (hb_data),
        .txd       (txd),
        .idle      (sh_idle)
    );

    assign empty_flag = active && !hb_full && sh_idle;
    assign tx_irq     = irq_enable && ready_flag;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx_enable,
    input logic sw_reset,
    input logic irq_enable,
    input logic txd,
    input logic ready_flag,
    input logic empty_flag,
    input logic tx_irq
);
    p_write_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_enable && !sw_reset) |=> !ready_flag);

    p_handoff_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_flag) |-> !txd);

    p_empty_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_flag |-> txd);

    p_masked_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |-> !tx_irq);

    p_unmasked_irq_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enable && ready_flag) |-> tx_irq);

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable || sw_reset) |=> (!ready_flag && txd));

    p_inactive_not_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable || sw_reset) |-> !empty_flag);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tx_enable  (tx_enable),
    .sw_reset   (sw_reset),
    .irq_enable (irq_enable),
    .txd        (txd),
    .ready_flag (ready_flag),
    .empty_flag (empty_flag),
    .tx_irq     (tx_irq)
);

// File: tb/test_uart_tx_dbuf.sv
`timescale 1ns/1ps
module test_uart_tx_dbuf;
    localparam int DW  = 8;
    localparam int TPB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic tx_enable = 1'b1;
    logic sw_reset = 1'b0;
    logic irq_enable = 1'b0;
    logic baud_tick = 1'b0;
    logic txd, ready_flag, empty_flag, tx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_div = 0;
    bit done = 0;

    // behavioural reference state
    bit m_full = 0, m_rdy = 0, m_busy = 0;
    logic [DW-1:0] m_data = '0;
    logic [DW+1:0] m_frame = '1;
    int m_pos = 0, m_tc = 0;

    always #4 clk = ~clk;

    uart_tx_dbuf #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) i_uart_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .sw_reset(sw_reset), .irq_enable(irq_enable),
        .baud_tick(baud_tick), .txd(txd), .ready_flag(ready_flag),
        .empty_flag(empty_flag), .tx_irq(tx_irq)
    );

    always @(posedge clk) begin
        #2;
        baud_tick = (tick_div == 0);
        tick_div = (tick_div + 1) % 3;
    end

    // reference model update, inputs are stable at the edge
    always @(posedge clk) begin
        bit en, old_full, old_busy;
        en = tx_enable && !sw_reset;
        old_full = m_full;
        old_busy = m_busy;
        if (!rst_n || !en) begin
            m_full = 0; m_rdy = 0; m_busy = 0; m_pos = 0; m_tc = 0;
        end else begin
            if (old_busy && baud_tick) begin
                if (m_tc == TPB - 1) begin
                    m_tc = 0;
                    if (m_pos == DW + 1) m_busy = 0;
                    else m_pos++;
                end else m_tc++;
            end
            if (old_full && !old_busy) begin
                m_busy = 1; m_pos = 0; m_tc = 0;
                m_frame = {1'b1, m_data, 1'b0};
                m_full = 0; m_rdy = 1;
            end
            if (wr_en) begin
                m_full = 1; m_data = wr_data; m_rdy = 0;
            end
        end
    end

    task automatic cmp(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            bit en;
            en = tx_enable && !sw_reset;
            cmp("R1 R2 R4 R8 R9 txd", txd, m_busy ? m_frame[m_pos] : 1'b1);
            cmp("R3 R7 R8 ready_flag", ready_flag, m_rdy);
            cmp("R5 R7 empty_flag", empty_flag, en && !m_full && !m_busy);
            cmp("R6 tx_irq", tx_irq, irq_enable && m_rdy);
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic put(input logic [DW-1:0] b);
        wr_en = 1'b1; wr_data = b;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic until_ready();
        for (int i = 0; i < 3000 && !ready_flag; i++) step(1);
    endtask

    task automatic until_empty();
        for (int i = 0; i < 3000 && !empty_flag; i++) step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        cmp("R10 txd", txd, 1'b1);
        cmp("R10 ready_flag", ready_flag, 1'b0);
        cmp("R10 tx_irq", tx_irq, 1'b0);
        cmp("R10 empty_flag", empty_flag, 1'b1);
        step(1);

        // back-to-back frames with interrupt enabled (R1 R2 R3 R4)
        irq_enable = 1'b1;
        put(8'hA5);
        until_ready();
        put(8'h3C);
        until_ready();
        put(8'h00);
        until_empty();
        step(5);

        // polling with interrupt masked, then unmask while ready (R6 R7)
        irq_enable = 1'b0;
        put(8'h81);
        until_ready();
        step(20);
        irq_enable = 1'b1;
        step(10);
        irq_enable = 1'b0;
        step(7);
        irq_enable = 1'b1;
        until_empty();

        // rewrite of a full holding register (R9)
        put(8'hFF);
        step(2);
        put(8'h12);
        put(8'h34);
        step(30);
        put(8'h56);
        until_empty();

        // disable mid-frame, write while disabled (R8)
        put(8'hC3);
        step(50);
        tx_enable = 1'b0;
        step(3);
        put(8'h77);
        step(10);
        tx_enable = 1'b1;
        step(20);

        // software reset mid-frame with byte queued (R8)
        put(8'h5A);
        step(1);
        put(8'h6B);
        step(40);
        sw_reset = 1'b1;
        step(2);
        sw_reset = 1'b0;
        step(20);
        put(8'h9E);
        until_empty();
        step(5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule